// File: doc/BRIEF.md
# Dead-Band Delay Generator

This block turns a single PWM waveform into a pair of gate-drive signals for a half bridge. Between the two drives it inserts dead time, during which neither switch is commanded on, so the high-side and low-side transistors are never conducting at the same moment and shoot-through is avoided. The block delays rising edges by one programmable cycle count and falling edges by a second, independent count. A two-bit polarity selector then maps the two delayed signals onto outputs A and B. A bypass control forwards the raw input to both outputs unchanged.

Each delay is measured in clock cycles and counts consecutive cycles at a level. A rising edge is passed on only after the input has stayed high for the whole rising delay. If the input drops before that, no pulse appears. A falling edge is stretched until the input has stayed low for the whole falling delay. Each delay setting is captured when its count starts, so a value written while a count is running takes effect from the next edge.

Top module: `dead_band_gen`

## Requirements
- R1: After reset, with `pwm_in` low, `bypass_en` low and `pol_sel` = 0, both `drv_a` and `drv_b` are 0.
- R2: The rise-delayed signal goes high in the clock cycle after the N-th consecutive rising clock edge at which `pwm_in` was sampled high, where N is the rise delay. It drops in the same cycle that `pwm_in` drops.
- R3: An input high pulse that lasts fewer than N sampled edges produces no pulse at all on the rise-delayed signal.
- R4: The fall-delayed signal is high whenever `pwm_in` is high. After `pwm_in` falls, it stays high until `pwm_in` has been sampled low at M consecutive rising edges, where M is the fall delay.
- R5: A delay value of 0 passes that edge with no delay: the output changes in the same cycle as `pwm_in`.
- R6: `pol_sel` encodes the polarity mode as follows. Value 0 gives A = rise-delayed, B = fall-delayed. Value 1 gives A = NOT rise-delayed, B = NOT fall-delayed. Value 2 gives A = rise-delayed, B = NOT fall-delayed. Value 3 gives A = NOT rise-delayed, B = fall-delayed.
- R7: With `pol_sel` = 2 and bypass off, `drv_a` and `drv_b` are never both 1. With `pol_sel` = 3 and bypass off, they are never both 0.
- R8: While `bypass_en` is 1, both `drv_a` and `drv_b` equal `pwm_in` in the same cycle.
- R9: The rise delay is sampled at every edge where `pwm_in` is low, and the fall delay at every edge where it is high. A change to `rise_cnt` while the input is high, or to `fall_cnt` while it is low, has no effect until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; delays count its rising edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | PWM waveform to be split |
| bypass_en | input | 1 | 1 forwards `pwm_in` to both outputs |
| pol_sel | input | 2 | Polarity mode, encoded as in R6 |
| rise_cnt | input | DLY_W (10) | Rising-edge delay in clock cycles |
| fall_cnt | input | DLY_W (10) | Falling-edge delay in clock cycles |
| drv_a | output | 1 | Drive output A |
| drv_b | output | 1 | Drive output B |

## Verification
The assertions assume that `pwm_in`, `pol_sel` and `bypass_en` are synchronous to `clk` and stable around its rising edge. They also assume the polarity relations are judged only while bypass is off. The stimulus changes every input only at the falling clock edge. It draws input run lengths, delays, modes and occasional bypass from a seeded generator, and it keeps delays small enough that many full counts complete within the run. Directed segments cover zero delay, pulses shorter than the delay, and delay changes while a count is running.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   typedef enum logic [1:0] {
      DBG_ACT_HI     = 2'd0,
      DBG_ACT_LO     = 2'd1,
      DBG_ACT_HI_CMP = 2'd2,
      DBG_ACT_LO_CMP = 2'd3
   } dbg_pol_e;
endpackage

// File: rtl/dbg_edge_delay.sv
// Delays one edge of pwm_i by a run-length count. RISE=1 delays rising
// edges; RISE=0 stretches the high level past falling edges.
module dbg_edge_delay #(
   parameter int DLY_W = 10,
   parameter bit RISE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             dly_o
);
   localparam logic [DLY_W-1:0] RUN_MAX  = '1;
   localparam logic [DLY_W-1:0] RUN_INIT = RISE ? '0 : RUN_MAX;

   logic             lvl;
   logic             core;
   logic [DLY_W-1:0] run_q;
   logic [DLY_W-1:0] lat_q;

   generate
      if (RISE) begin : g_rise_in
         assign lvl = pwm_i;
      end else begin : g_fall_in
         assign lvl = ~pwm_i;
      end
   endgenerate

   // run_q: consecutive sampled edges at the active level (saturating)
   // lat_q: delay captured while idle, frozen while a count runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= RUN_INIT;
         lat_q <= '0;
      end else begin
         if (lvl) begin
            if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
         end else begin
            run_q <= '0;
         end
         if (!lvl) lat_q <= dly_i;
      end
   end

   assign core = lvl && (run_q >= lat_q);

   generate
      if (RISE) begin : g_rise_out
         assign dly_o = core;
      end else begin : g_fall_out
         assign dly_o = ~core;
      end
   endgenerate
endmodule

// File: rtl/dbg_pol_mux.sv
module dbg_pol_mux
   import dbg_pkg::*;
(
   input  logic     red_i,
   input  logic     fed_i,
   input  logic     pwm_i,
   input  logic     bypass_i,
   input  dbg_pol_e pol_i,
   output logic     a_o,
   output logic     b_o
);
   always_comb begin
      if (bypass_i) begin
         a_o = pwm_i;
         b_o = pwm_i;
      end else begin
         unique case (pol_i)
            DBG_ACT_HI:     begin a_o =  red_i; b_o =  fed_i; end
            DBG_ACT_LO:     begin a_o = ~red_i; b_o = ~fed_i; end
            DBG_ACT_HI_CMP: begin a_o =  red_i; b_o = ~fed_i; end
            default:        begin a_o = ~red_i; b_o =  fed_i; end
         endcase
      end
   end
endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen
   import dbg_pkg::*;
#(
   parameter int DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   input  logic             bypass_en,
   input  logic [1:0]       pol_sel,
   input  logic [DLY_W-1:0] rise_cnt,
   input  logic [DLY_W-1:0] fall_cnt,
   output logic             drv_a,
   output logic             drv_b
);
   generate
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_width
         $error("dead_band_gen: DLY_W must lie in 1..16");
      end
   endgenerate

   logic red;
   logic fed;

   dbg_edge_delay #(.DLY_W(DLY_W), .RISE(1'b1)) u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .pwm_i (pwm_in),
      .dly_i (rise_cnt),
      .dly_o (red)
   );

   dbg_edge_delay #(.DLY_W(DLY_W), .RISE(1'b0)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .pwm_i (pwm_in),
      .dly_i (fall_cnt),
      .dly_o (fed)
   );

   dbg_pol_mux u_mux (
      .red_i    (red),
      .fed_i    (fed),
      .pwm_i    (pwm_in),
      .bypass_i (bypass_en),
      .pol_i    (dbg_pol_e'(pol_sel)),
      .a_o      (drv_a),
      .b_o      (drv_b)
   );
endmodule

// File: rtl/dbg_chk.sv
module dbg_chk #(
   parameter int DLY_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_in,
   input logic             bypass_en,
   input logic [1:0]       pol_sel,
   input logic [DLY_W-1:0] rise_cnt,
   input logic [DLY_W-1:0] fall_cnt,
   input logic             drv_a,
   input logic             drv_b
);
   a_r7_hi_cmp_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_en && pol_sel == 2'd2) |-> !(drv_a && drv_b));

   a_r7_lo_cmp_never_both_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_en && pol_sel == 2'd3) |-> (drv_a || drv_b));

   a_r8_bypass_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_en |-> (drv_a == pwm_in && drv_b == pwm_in));

   a_r2_rise_needs_input_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_en && pol_sel == 2'd0 && drv_a) |-> pwm_in);

   a_r4_fall_covers_input: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_en && pol_sel == 2'd0 && pwm_in) |-> drv_b);

   a_r6_lo_mode_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_en && pol_sel == 2'd1 && !pwm_in) |-> drv_a);
endmodule

bind dead_band_gen dbg_chk #(.DLY_W(DLY_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwm_in    (pwm_in),
   .bypass_en (bypass_en),
   .pol_sel   (pol_sel),
   .rise_cnt  (rise_cnt),
   .fall_cnt  (fall_cnt),
   .drv_a     (drv_a),
   .drv_b     (drv_b)
);

// File: tb/sim_dead_band_gen.sv
module sim_dead_band_gen;
   localparam int CLK_P = 10;
   localparam int DW    = 10;
   localparam int SAT   = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwm = 1'b0;
   logic          byp = 1'b0;
   logic [1:0]    pol = 2'd0;
   logic [DW-1:0] rdly = '0;
   logic [DW-1:0] fdly = '0;
   logic          drv_a, drv_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int hr, lr, rl, fl;

   always #(CLK_P/2) clk = ~clk;

   dead_band_gen #(.DLY_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .bypass_en(byp),
      .pol_sel(pol), .rise_cnt(rdly), .fall_cnt(fdly),
      .drv_a(drv_a), .drv_b(drv_b)
   );

   function automatic logic [1:0] model_out();
      logic red, fed;
      red = pwm && (hr >= rl);
      fed = pwm || (lr < fl);
      if (byp) return {pwm, pwm};
      case (pol)
         2'd0:    return { red,  fed};
         2'd1:    return {~red, ~fed};
         2'd2:    return { red, ~fed};
         default: return {~red,  fed};
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [1:0] e;
      e = model_out();
      checks++;
      if ({drv_a, drv_b} !== e) begin
         fails++;
         $display("FAIL %s: t=%0t pwm=%0b pol=%0d byp=%0b actual a=%0b b=%0b expected a=%0b b=%0b",
                  tag, $time, pwm, pol, byp, drv_a, drv_b, e[1], e[0]);
      end
   endtask

   // one clock: model advances with the DUT edge, compare at falling edge
   task automatic cyc(input string tag);
      int nrl, nfl;
      @(posedge clk);
      nrl = pwm ? rl : int'(rdly);
      nfl = pwm ? int'(fdly) : fl;
      if (pwm) begin
         if (hr < SAT) hr++;
         lr = 0;
      end else begin
         hr = 0;
         if (lr < SAT) lr++;
      end
      rl = nrl;
      fl = nfl;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic run(input logic p, input int n, input string tag);
      pwm = p;
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int seed;
      int n;
      seed = 32'h5eed_d0b1;
      void'($urandom(seed));
      hr = 0; lr = SAT; rl = 0; fl = 0;
      rdly = 10'd3; fdly = 10'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      checks++;
      if (drv_a !== 1'b0 || drv_b !== 1'b0) begin
         fails++;
         $display("FAIL R1: actual a=%0b b=%0b expected a=0 b=0", drv_a, drv_b);
      end
      run(1'b0, 4, "R1");

      // R5 zero delays pass edges at once
      rdly = 0; fdly = 0;
      run(1'b0, 1, "R5");
      run(1'b1, 1, "R5"); run(1'b0, 1, "R5"); run(1'b1, 3, "R5"); run(1'b0, 2, "R5");

      // R2 rising delay of 5
      rdly = 5;
      run(1'b0, 3, "R2");
      run(1'b1, 10, "R2");
      run(1'b0, 2, "R2");

      // R3 short pulse swallowed
      rdly = 6;
      run(1'b0, 2, "R3");
      run(1'b1, 4, "R3");
      run(1'b0, 3, "R3");
      run(1'b1, 5, "R3");
      run(1'b0, 3, "R3");

      // R4 falling delay of 7
      rdly = 0; fdly = 7;
      run(1'b1, 3, "R4");
      run(1'b0, 12, "R4");
      run(1'b1, 2, "R4"); run(1'b0, 3, "R4"); run(1'b1, 1, "R4"); run(1'b0, 10, "R4");

      // R7 complementary dead time
      pol = 2'd2; rdly = 3; fdly = 4;
      for (int k = 0; k < 6; k++) begin
         run(1'b1, 2 + k, "R7");
         run(1'b0, 1 + k, "R7");
         checks++;
         if (drv_a && drv_b) begin
            fails++;
            $display("FAIL R7: actual a=1 b=1 expected not both high");
         end
      end
      pol = 2'd3;
      for (int k = 0; k < 4; k++) begin run(1'b1, 6, "R7"); run(1'b0, 6, "R7"); end

      // R6 each polarity code
      rdly = 2; fdly = 3;
      for (int m = 0; m < 4; m++) begin
         pol = 2'(m);
         run(1'b0, 5, "R6"); run(1'b1, 6, "R6"); run(1'b0, 5, "R6");
      end

      // R9 delay change while a count runs
      pol = 2'd0; rdly = 8; fdly = 0;
      run(1'b0, 2, "R9");
      run(1'b1, 2, "R9");
      rdly = 1;
      run(1'b1, 10, "R9");
      fdly = 6;
      run(1'b1, 1, "R9");
      run(1'b0, 1, "R9");
      fdly = 0;
      run(1'b0, 10, "R9");

      // R8 bypass
      byp = 1'b1; rdly = 9; fdly = 9;
      for (int i = 0; i < 20; i++) run(1'($urandom_range(0, 1)), 1, "R8");
      byp = 1'b0;

      // random mix
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 3) == 0) rdly = DW'($urandom_range(0, 12));
         if ($urandom_range(0, 3) == 0) fdly = DW'($urandom_range(0, 12));
         if ($urandom_range(0, 7) == 0) pol  = 2'($urandom_range(0, 3));
         byp = ($urandom_range(0, 7) == 0);
         n = $urandom_range(1, 16);
         run(~pwm, n, "R6");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule